// File: doc/BRIEF.md
# Echo-Clocked Multi-Lane Sample Deserializer

This block receives the output of a two-channel sampling converter whose serial data lanes are timed by a strobe that the converter returns to the host. The host's own serial clock is not used for this. The strobe enters on `echo_clk`. A frame qualifier, `frame_act`, is high for the whole of each conversion readout. Each frame carries one sample per channel. The block shifts the lane bits into per-lane registers and rebuilds both channel words. It then passes the finished pair across to the system clock domain. There it is presented as one beat of a valid/ready stream for a DMA engine.

Three build-time parameters set the physical format. `NLANES` is 1, 2, 4 or 8. With 1, a single lane carries channel 0's word first and channel 1's word after it. With 2, 4 and 8, each channel has 1, 2 or 4 lanes of its own. `DDR` selects whether bits are taken on one edge or on both edges of the echoed strobe. `SAMPLE_W` is 16 or 24.

Stream rules: a beat is offered with `m_valid` high. It stays unchanged until `m_ready` is seen high on a `sys_clk` edge. The consumer should take each beat before the next frame completes. If a frame completes while a beat is still waiting, the new pair is dropped, the waiting beat is kept, and the sticky `frame_err` flag is raised.

Top module: `echo_adc_deser`

## Requirements
- R1: While `sys_rst_n` is low, and right after it is released, `m_valid` and `frame_err` are 0.
- R2: With `NLANES` of 2, 4 or 8, let L = NLANES/2. Channel c uses lanes c*L through c*L+L-1. Lane c*L+k carries sample bits k, k+L, k+2L and so on, with bit positions counted from the MSB, so the MSB comes first.
- R3: With `DDR`=1, each lane gives two bits per `echo_clk` period. The bit sampled on the rising edge precedes the bit sampled on the falling edge in that lane's sequence.
- R4: With `NLANES`=1, lane 0 carries all of channel 0's word MSB first, and then all of channel 1's word MSB first.
- R5: A pair is completed after exactly (bits per lane)/(1+DDR) capturing edges of a frame. The bits per lane are 2*SAMPLE_W in interleaved mode and SAMPLE_W/L otherwise. The edge counter returns to zero whenever `frame_act` is low, so a later full frame is assembled correctly.
- R6: Each complete frame yields exactly one stream beat. `m_data[SAMPLE_W-1:0]` is channel 0 and `m_data[2*SAMPLE_W-1:SAMPLE_W]` is channel 1.
- R7: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` does not change.
- R8: A frame in which `frame_act` falls before the pair completes produces no beat and sets `frame_err`. Complete frames leave `frame_err` at 0.
- R9: A pair that completes while a beat is waiting unaccepted is dropped, and `frame_err` is set. The waiting beat is delivered unchanged.
- R10: `frame_err` stays at 1 until `sys_rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the stream side |
| sys_rst_n | input | 1 | Active-low asynchronous reset for both domains |
| echo_clk | input | 1 | Bit strobe returned by the converter |
| frame_act | input | 1 | High during a readout frame |
| sdo_lanes | input | NLANES | Serial data lanes |
| m_valid | output | 1 | Stream beat available |
| m_ready | input | 1 | Consumer accepts the beat |
| m_data | output | 2*SAMPLE_W | Channel 1 word above channel 0 word |
| frame_err | output | 1 | Sticky short-frame or overrun flag |

## Verification
The assertions assume that `echo_clk` toggles only while `frame_act` is high. They also assume that `frame_act` stays low for at least two `sys_clk` periods between frames. Finally, they assume that completed pairs are spaced far enough apart for the toggle handshake to settle, so that the holding register is stable whenever the system side reads it. The stimulus follows these assumptions. It raises the qualifier before the first strobe edge and drops it after the last one. Every frame is followed by an idle gap many system cycles long. Lane bits change half a strobe phase before the edge that samples them.

// File: rtl/ecd_pkg.sv
package ecd_pkg;
  // Bits each lane carries per frame.
  function automatic int lane_depth(input int nlanes, input int width);
    if (nlanes == 1) return 2 * width;
    return width / (nlanes / 2);
  endfunction
endpackage

// File: rtl/ecd_capture.sv
module ecd_capture
  import ecd_pkg::*;
#(
  parameter int NLANES   = 8,
  parameter int SAMPLE_W = 24,
  parameter int DDR      = 0
) (
  input  logic                  rst_n,
  input  logic                  echo_clk,
  input  logic                  frame_act,
  input  logic [NLANES-1:0]     lanes,
  output logic [2*SAMPLE_W-1:0] hold_o,
  output logic                  tog_o
);
  localparam int E   = (DDR != 0) ? 2 : 1;
  localparam int D   = lane_depth(NLANES, SAMPLE_W);
  localparam int CNT = D / E;
  localparam int CW  = (CNT > 1) ? $clog2(CNT) : 1;
  localparam int LPC = (NLANES == 1) ? 1 : NLANES / 2;

  logic cap_clk;
  logic cnt_rst_n;
  logic [NLANES-1:0][E-1:0] nb;
  logic [NLANES-1:0][D-1:0] sr, sr_nx;
  logic [2*SAMPLE_W-1:0]    asm_w;
  logic [CW-1:0]            cnt;
  logic                     last;

  assign cap_clk   = (DDR != 0) ? ~echo_clk : echo_clk;
  assign cnt_rst_n = rst_n & frame_act;
  assign last      = (cnt == CW'(CNT - 1));

  if (DDR != 0) begin : g_ddr
    logic [NLANES-1:0] rise_q;
    always_ff @(posedge echo_clk) rise_q <= lanes;
    always_comb
      for (int l = 0; l < NLANES; l++) nb[l] = {rise_q[l], lanes[l]};
  end else begin : g_sdr
    always_comb nb = lanes;
  end

  always_comb
    for (int l = 0; l < NLANES; l++) sr_nx[l] = {sr[l][D-1-E:0], nb[l]};

  if (NLANES == 1) begin : g_ilv
    always_comb begin
      asm_w[SAMPLE_W-1:0]          = sr_nx[0][2*SAMPLE_W-1:SAMPLE_W];
      asm_w[2*SAMPLE_W-1:SAMPLE_W] = sr_nx[0][SAMPLE_W-1:0];
    end
  end else begin : g_multi
    always_comb begin
      asm_w = '0;
      for (int c = 0; c < 2; c++)
        for (int k = 0; k < LPC; k++)
          for (int i = 0; i < D; i++)
            asm_w[c*SAMPLE_W + SAMPLE_W-1 - (i*LPC + k)] = sr_nx[c*LPC + k][D-1-i];
    end
  end

  always_ff @(posedge cap_clk)
    if (frame_act) sr <= sr_nx;

  always_ff @(posedge cap_clk or negedge cnt_rst_n)
    if (!cnt_rst_n)  cnt <= '0;
    else if (last)   cnt <= '0;
    else             cnt <= cnt + 1'b1;

  always_ff @(posedge cap_clk or negedge rst_n)
    if (!rst_n)                 tog_o <= 1'b0;
    else if (frame_act && last) tog_o <= ~tog_o;

  always_ff @(posedge cap_clk)
    if (frame_act && last) hold_o <= asm_w;

  // R5: the edge counter never passes the last edge of a frame
  assert_cnt_range_R5: assert property (@(posedge cap_clk) disable iff (!cnt_rst_n)
    cnt <= CW'(CNT - 1));
endmodule

// File: rtl/ecd_handoff.sv
module ecd_handoff #(
  parameter int DW = 48
) (
  input  logic          sys_clk,
  input  logic          rst_n,
  input  logic          tog_i,
  input  logic [DW-1:0] hold_i,
  input  logic          frame_act,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data,
  output logic          frame_err
);
  logic [2:0] t_s, f_s;
  logic       tog_edge, f_rise, f_fall, seen;

  assign tog_edge = t_s[2] ^ t_s[1];
  assign f_rise   = f_s[1] & ~f_s[2];
  assign f_fall   = ~f_s[1] & f_s[2];

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) begin
      t_s <= '0;
      f_s <= '0;
    end else begin
      t_s <= {t_s[1:0], tog_i};
      f_s <= {f_s[1:0], frame_act};
    end

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n)        seen <= 1'b0;
    else if (tog_edge) seen <= 1'b1;
    else if (f_rise)   seen <= 1'b0;

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) frame_err <= 1'b0;
    else if ((f_fall && !seen && !tog_edge) || (tog_edge && m_valid && !m_ready))
      frame_err <= 1'b1;

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (tog_edge && (!m_valid || m_ready)) begin
      m_valid <= 1'b1;
      m_data  <= hold_i;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end

  assert_hold_R7: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  assert_sticky_R10: assert property (@(posedge sys_clk) disable iff (!rst_n)
    frame_err |=> frame_err);
  assert_overrun_R9: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (tog_edge && m_valid && !m_ready) |=> frame_err);
  assert_drop_keep_R9: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $fell(m_valid) |-> $past(m_ready));
endmodule

// File: rtl/echo_adc_deser.sv
module echo_adc_deser #(
  parameter int NLANES   = 8,
  parameter int SAMPLE_W = 24,
  parameter int DDR      = 0
) (
  input  logic                  sys_clk,
  input  logic                  sys_rst_n,
  input  logic                  echo_clk,
  input  logic                  frame_act,
  input  logic [NLANES-1:0]     sdo_lanes,
  output logic                  m_valid,
  input  logic                  m_ready,
  output logic [2*SAMPLE_W-1:0] m_data,
  output logic                  frame_err
);
  localparam int DW = 2 * SAMPLE_W;

  logic [DW-1:0] hold;
  logic          tog;

  ecd_capture #(.NLANES(NLANES), .SAMPLE_W(SAMPLE_W), .DDR(DDR)) u_cap (
    .rst_n(sys_rst_n), .echo_clk(echo_clk), .frame_act(frame_act),
    .lanes(sdo_lanes), .hold_o(hold), .tog_o(tog)
  );

  ecd_handoff #(.DW(DW)) u_hof (
    .sys_clk(sys_clk), .rst_n(sys_rst_n), .tog_i(tog), .hold_i(hold),
    .frame_act(frame_act), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .frame_err(frame_err)
  );
endmodule

// File: tb/sim_echo_adc_deser.sv
module sim_echo_adc_deser;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic ec0 = 0, ec1 = 0, ec2 = 0;
  logic fr0 = 0, fr1 = 0, fr2 = 0;
  logic [7:0] ln0 = '0;
  logic [0:0] ln1 = '0;
  logic [3:0] ln2 = '0;
  logic rdy0 = 1, rdy1 = 1, rdy2 = 1;
  logic v0, v1, v2, e0, e1, e2;
  logic [47:0] d0;
  logic [31:0] d1;
  logic [47:0] d2;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [63:0] q0[$], q1[$], q2[$];

  echo_adc_deser #(.NLANES(8), .SAMPLE_W(24), .DDR(0)) u0 (
    .sys_clk(clk), .sys_rst_n(rst_n), .echo_clk(ec0), .frame_act(fr0), .sdo_lanes(ln0),
    .m_valid(v0), .m_ready(rdy0), .m_data(d0), .frame_err(e0));
  echo_adc_deser #(.NLANES(1), .SAMPLE_W(16), .DDR(1)) u1 (
    .sys_clk(clk), .sys_rst_n(rst_n), .echo_clk(ec1), .frame_act(fr1), .sdo_lanes(ln1),
    .m_valid(v1), .m_ready(rdy1), .m_data(d1), .frame_err(e1));
  echo_adc_deser #(.NLANES(4), .SAMPLE_W(24), .DDR(1)) u2 (
    .sys_clk(clk), .sys_rst_n(rst_n), .echo_clk(ec2), .frame_act(fr2), .sdo_lanes(ln2),
    .m_valid(v2), .m_ready(rdy2), .m_data(d2), .frame_err(e2));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Behavioural encoder: bit on lane l at per-lane sequence index i
  function automatic logic lbit(input int nl, input int w, input logic [31:0] c0,
                                input logic [31:0] c1, input int l, input int i);
    int lpc, j;
    logic [31:0] wd;
    if (nl == 1) begin
      if (i < w) return c0[w-1-i];
      return c1[w-1-(i-w)];
    end
    lpc = nl / 2;
    wd  = (l / lpc) != 0 ? c1 : c0;
    j   = i * lpc + (l % lpc);
    return wd[w-1-j];
  endfunction

  task automatic put_lane(input int sel, input int l, input logic b);
    case (sel)
      0: ln0[l] = b;
      1: ln1[0] = b;
      default: ln2[l] = b;
    endcase
  endtask

  task automatic put_clk(input int sel, input logic b);
    case (sel) 0: ec0 = b; 1: ec1 = b; default: ec2 = b; endcase
  endtask

  task automatic put_fr(input int sel, input logic b);
    case (sel) 0: fr0 = b; 1: fr1 = b; default: fr2 = b; endcase
  endtask

  // Send one frame; ncyc < full length makes a short frame
  task automatic send(input int sel, input logic [31:0] c0, input logic [31:0] c1,
                      input int ncyc);
    int nl, w, ee;
    case (sel)
      0: begin nl = 8; w = 24; ee = 1; end
      1: begin nl = 1; w = 16; ee = 2; end
      default: begin nl = 4; w = 24; ee = 2; end
    endcase
    put_fr(sel, 1'b1);
    #20;
    for (int t = 0; t < ncyc; t++) begin
      for (int l = 0; l < nl; l++) put_lane(sel, l, lbit(nl, w, c0, c1, l, t*ee));
      #10 put_clk(sel, 1'b1);
      #10;
      if (ee == 2)
        for (int l = 0; l < nl; l++) put_lane(sel, l, lbit(nl, w, c0, c1, l, t*ee+1));
      #10 put_clk(sel, 1'b0);
      #10;
    end
    #20 put_fr(sel, 1'b0);
    #300;
  endtask

  function automatic logic [63:0] pack(input int w, input logic [31:0] c0, input logic [31:0] c1);
    logic [63:0] m;
    m = (64'd1 << w) - 64'd1;
    return ((64'(c1) & m) << w) | (64'(c0) & m);
  endfunction

  // Per-clock comparison of accepted beats against the reference queues
  always @(negedge clk) if (rst_n) begin
    if (v0 && rdy0) begin
      if (q0.size() == 0) chk("R6 u0 unexpected beat", 64'(d0), 64'hX);
      else chk("R2 u0 lane mapping", 64'(d0), q0.pop_front());
    end
    if (v1 && rdy1) begin
      if (q1.size() == 0) chk("R6 u1 unexpected beat", 64'(d1), 64'hX);
      else chk("R4 u1 interleaved", 64'(d1), q1.pop_front());
    end
    if (v2 && rdy2) begin
      if (q2.size() == 0) chk("R6 u2 unexpected beat", 64'(d2), 64'hX);
      else chk("R3 u2 ddr order", 64'(d2), q2.pop_front());
    end
  end

  initial begin : watchdog
    for (int n = 0; n < 150000; n++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [47:0] snap;
    repeat (5) @(posedge clk);
    #2;
    chk("R1 valid in reset", {61'd0, v0, v1, v2}, 64'd0);
    chk("R1 err in reset", {61'd0, e0, e1, e2}, 64'd0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 valid after reset", {61'd0, v0, v1, v2}, 64'd0);

    // R2, R6: eight lanes, single edge
    q0.push_back(pack(24, 32'hABCDEF, 32'h123456)); send(0, 32'hABCDEF, 32'h123456, 6);
    q0.push_back(pack(24, 32'hFFFFFF, 32'h000000)); send(0, 32'hFFFFFF, 32'h000000, 6);
    q0.push_back(pack(24, 32'h800001, 32'h7FFFFE)); send(0, 32'h800001, 32'h7FFFFE, 6);
    chk("R6 u0 one beat per frame", 64'(q0.size()), 64'd0);
    chk("R8 u0 no error on full frames", 64'(e0), 64'd0);

    // R7: back-pressure
    @(posedge clk); #2 rdy0 = 0;
    q0.push_back(pack(24, 32'h5A5A5A, 32'hC3C3C3)); send(0, 32'h5A5A5A, 32'hC3C3C3, 6);
    snap = d0;
    chk("R7 valid held", 64'(v0), 64'd1);
    repeat (10) @(posedge clk);
    #2;
    chk("R7 valid still held", 64'(v0), 64'd1);
    chk("R7 data stable", 64'(d0), 64'(snap));
    rdy0 = 1;
    repeat (3) @(posedge clk);
    chk("R7 beat drained", 64'(q0.size()), 64'd0);

    // R8, R5, R10: short frame then full frame
    send(0, 32'h111111, 32'h222222, 3);
    chk("R8 short frame error", 64'(e0), 64'd1);
    chk("R8 short frame no beat", 64'(v0), 64'd0);
    q0.push_back(pack(24, 32'h13579B, 32'h2468AC)); send(0, 32'h13579B, 32'h2468AC, 6);
    chk("R5 counter cleared, full frame delivered", 64'(q0.size()), 64'd0);
    chk("R10 error stays set", 64'(e0), 64'd1);

    // R4, R3: interleaved DDR single lane
    q1.push_back(pack(16, 32'hA5C3, 32'h0F0F)); send(1, 32'hA5C3, 32'h0F0F, 16);
    q1.push_back(pack(16, 32'h1234, 32'hFEDC)); send(1, 32'h1234, 32'hFEDC, 16);
    chk("R4 u1 beats delivered", 64'(q1.size()), 64'd0);
    chk("R8 u1 no error", 64'(e1), 64'd0);

    // R9: overrun drops the newer pair
    @(posedge clk); #2 rdy1 = 0;
    q1.push_back(pack(16, 32'h8001, 32'h7FFE)); send(1, 32'h8001, 32'h7FFE, 16);
    send(1, 32'hDEAD, 32'hBEEF, 16);
    chk("R9 overrun error", 64'(e1), 64'd1);
    chk("R9 older beat kept", 64'(d1), pack(16, 32'h8001, 32'h7FFE));
    rdy1 = 1;
    repeat (3) @(posedge clk);
    #2;
    chk("R9 newer pair dropped", 64'(v1), 64'd0);
    chk("R9 queue drained", 64'(q1.size()), 64'd0);

    // R3: four lanes, both edges
    q2.push_back(pack(24, 32'h96A5F0, 32'h0C3F81)); send(2, 32'h96A5F0, 32'h0C3F81, 6);
    q2.push_back(pack(24, 32'h000001, 32'h800000)); send(2, 32'h000001, 32'h800000, 6);
    chk("R3 u2 beats delivered", 64'(q2.size()), 64'd0);
    chk("R8 u2 no error", 64'(e2), 64'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule